// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block sits on the host side of a serial link to a wireless module's SPI slave. When it receives a start strobe it takes an opcode, a 24-bit address, a 32-bit argument word (a transfer size or a data word, depending on the opcode), a clockless flag and a CRC-enable flag. It then shifts one complete command frame out through a built-in mode-0 SPI master. The frame starts with the opcode, followed by that opcode's own fields. An optional CRC7 byte comes next. The block then sends enough zero bytes for the slave's reply to be clocked back while chip select is still low.

Every byte clocked in on MISO during the window goes to a downstream response parser through a valid-strobed byte output. At the end of the window the block pulses `done` and reports how many bytes it clocked. An opcode outside the supported set is refused: the block pulses `bad_op` and sends nothing.

The control path is a four-state machine:
- `ST_IDLE`: waits for a start.
- `ST_SEND`: hands the next byte to the shifter.
- `ST_WAIT`: waits for that byte to finish.
- `ST_DONE`: the one-cycle completion state.

Its transitions are:
- **accept**: `ST_IDLE` to `ST_SEND`, on a start with a valid opcode.
- **reject**: `ST_IDLE` back to `ST_IDLE`, with `bad_op`.
- **launch**: `ST_SEND` to `ST_WAIT`.
- **next**: `ST_WAIT` to `ST_SEND`, when a byte ends and more remain.
- **last**: `ST_WAIT` to `ST_DONE`, when the final byte ends.
- **release**: `ST_DONE` to `ST_IDLE`.

Top module: `spi_cmd_framer`

## Requirements
- R1: Opcodes 0xC1 to 0xCA and 0xCF are accepted. Any other opcode makes `bad_op` high for exactly the cycle after the start, with `busy` low, `cs_n` high, no SCLK edge and no `done`.
- R2: Opcode 0xCA (single read) sends the address bytes addr[23:16], addr[15:8], addr[7:0] after the opcode. Opcode 0xC9 (single write) sends the same address bytes, then arg[31:24], arg[23:16], arg[15:8], arg[7:0].
- R3: Opcodes 0xC4 (internal read) and 0xC3 (internal write) send addr[15:8] with bit 7 forced to 1 when `clockless` is high, then addr[7:0]. After that, 0xC4 sends one 0x00 byte and 0xC3 sends arg from its most significant byte down.
- R4: Opcodes 0xC5 (terminate) and 0xC6 (repeat) send three 0x00 bytes after the opcode. Opcode 0xCF (reset) sends three 0xFF bytes after the opcode.
- R5: Opcodes 0xC1 and 0xC2 send the three address bytes, then arg[15:8] and arg[7:0]. Opcodes 0xC7 and 0xC8 send the three address bytes, then arg[23:16], arg[15:8] and arg[7:0].
- R6: With `crc_en` high, a CRC byte follows the fields. The CRC is computed over all preceding frame bytes, MSB first, with polynomial x^7+x^3+1 and initial value 0x7F. The CRC sits in bits 7:1 of the byte and bit 0 is 0.
- R7: With `crc_en` low, the CRC byte is left out and the padding follows the fields directly.
- R8: Zero padding after the frame is 6 bytes for 0xC5, 0xC6 and 0xCF. It is 10 bytes (CRC on) or 8 bytes (CRC off) for 0xCA and 0xC4. It is 5 bytes for all other opcodes. `byte_count` at `done` equals fields + CRC + padding.
- R9: All bytes go out inside one continuous `cs_n`-low window. SCLK idles low, MOSI sends MSB first and is stable on each rising SCLK edge, and MISO is sampled on the rising edge.
- R10: A start while `busy` is high is ignored: the frame in flight is unchanged and no second frame follows.
- R11: `busy` is high from the cycle after an accepted start up to and including the single cycle in which `done` is high, and low after that.
- R12: After each byte, `rx_valid` pulses once and `rx_byte` holds the 8 MISO bits sampled for that byte, first bit in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send one frame |
| opcode | input | 8 | Command opcode |
| addr | input | 24 | Address field source |
| arg | input | 32 | Size or data word |
| clockless | input | 1 | Sets bit 7 of the high address byte for internal commands |
| crc_en | input | 1 | Include the CRC7 byte |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_op | output | 1 | One-cycle pulse for a refused opcode |
| byte_count | output | CNT_W | Bytes clocked in the last frame |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| rx_valid | output | 1 | Strobe for a received byte |
| rx_byte | output | 8 | Received byte |

## Verification
The bench targets the cases where one opcode's layout could leak into another's. Examples are the internal commands with and without the clockless bit, the 16-bit versus 24-bit size fields, and the read opcodes whose padding depends on CRC. A design that got any of these wrong would put a wrong byte on MOSI or clock the wrong number of bytes. The bench also injects a start in the middle of a frame and sends unsupported opcodes next to the valid range (0xC0, 0xCB, 0xCE). A design that re-armed on the stray start would corrupt or repeat the frame, and one that failed to refuse a bad opcode would drop chip select. The received-byte stream is compared against a position-dependent MISO pattern, so a shifter that samples on the wrong edge or misorders bits shows up as shifted data.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam int HDR_MAX = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } fsm_t;

    localparam logic [7:0] OP_DMA_WR  = 8'hC1;
    localparam logic [7:0] OP_DMA_RD  = 8'hC2;
    localparam logic [7:0] OP_INT_WR  = 8'hC3;
    localparam logic [7:0] OP_INT_RD  = 8'hC4;
    localparam logic [7:0] OP_TERM    = 8'hC5;
    localparam logic [7:0] OP_REPEAT  = 8'hC6;
    localparam logic [7:0] OP_XDMA_WR = 8'hC7;
    localparam logic [7:0] OP_XDMA_RD = 8'hC8;
    localparam logic [7:0] OP_SGL_WR  = 8'hC9;
    localparam logic [7:0] OP_SGL_RD  = 8'hCA;
    localparam logic [7:0] OP_RESET   = 8'hCF;

    // One byte of CRC7 (x^7 + x^3 + 1), most significant bit first.
    function automatic logic [6:0] crc7_step(input logic [6:0] c_in, input logic [7:0] d);
        logic [6:0] c;
        logic fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[6] ^ d[i];
            c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_frame_layout.sv
module spi_frame_layout
    import spi_frame_pkg::*;
(
    input  logic [7:0]              op,
    input  logic [23:0]             addr,
    input  logic [31:0]             arg,
    input  logic                    clockless,
    input  logic                    crc_en,
    output logic [HDR_MAX-1:0][7:0] hdr,
    output logic [3:0]              hdr_len,
    output logic [3:0]              pad_len,
    output logic                    op_ok
);

    logic [7:0] int_hi;
    assign int_hi = {addr[15] | clockless, addr[14:8]};

    always_comb begin
        hdr     = '0;
        hdr[0]  = op;
        hdr_len = 4'd4;
        pad_len = 4'd5;
        op_ok   = 1'b1;
        unique case (op)
            OP_SGL_RD: begin
                hdr[1] = addr[23:16]; hdr[2] = addr[15:8]; hdr[3] = addr[7:0];
                pad_len = crc_en ? 4'd10 : 4'd8;
            end
            OP_SGL_WR: begin
                hdr[1] = addr[23:16]; hdr[2] = addr[15:8]; hdr[3] = addr[7:0];
                hdr[4] = arg[31:24]; hdr[5] = arg[23:16];
                hdr[6] = arg[15:8];  hdr[7] = arg[7:0];
                hdr_len = 4'd8;
            end
            OP_INT_RD: begin
                hdr[1] = int_hi; hdr[2] = addr[7:0]; hdr[3] = 8'h00;
                pad_len = crc_en ? 4'd10 : 4'd8;
            end
            OP_INT_WR: begin
                hdr[1] = int_hi; hdr[2] = addr[7:0];
                hdr[3] = arg[31:24]; hdr[4] = arg[23:16];
                hdr[5] = arg[15:8];  hdr[6] = arg[7:0];
                hdr_len = 4'd7;
            end
            OP_TERM, OP_REPEAT: begin
                pad_len = 4'd6;
            end
            OP_RESET: begin
                hdr[1] = 8'hFF; hdr[2] = 8'hFF; hdr[3] = 8'hFF;
                pad_len = 4'd6;
            end
            OP_DMA_WR, OP_DMA_RD: begin
                hdr[1] = addr[23:16]; hdr[2] = addr[15:8]; hdr[3] = addr[7:0];
                hdr[4] = arg[15:8];   hdr[5] = arg[7:0];
                hdr_len = 4'd6;
            end
            OP_XDMA_WR, OP_XDMA_RD: begin
                hdr[1] = addr[23:16]; hdr[2] = addr[15:8]; hdr[3] = addr[7:0];
                hdr[4] = arg[23:16];  hdr[5] = arg[15:8]; hdr[6] = arg[7:0];
                hdr_len = 4'd7;
            end
            default: begin
                op_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spi_crc7_accum.sv
module spi_crc7_accum
    import spi_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [6:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= 7'h7F;
        else if (en)  crc <= crc7_step(crc, din);
    end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

    logic          active;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cnt       <= '0;
            bitn      <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (load && !active) begin
                active <= 1'b1;
                tx_sh  <= tx_byte;
                cnt    <= '0;
                bitn   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (cnt == CNT_TOP) begin
                    cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                            rx_byte   <= rx_sh;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            tx_sh <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign mosi = tx_sh[7];

endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import spi_frame_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [23:0]      addr,
    input  logic [31:0]      arg,
    input  logic             clockless,
    input  logic             crc_en,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             bad_op,
    output logic [CNT_W-1:0] byte_count,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic             rx_valid,
    output logic [7:0]       rx_byte
);

    fsm_t state, nxt;

    logic [HDR_MAX-1:0][7:0] l_hdr, hdr_q;
    logic [3:0]              l_hdr_len, l_pad_len, hdr_len_q;
    logic                    l_ok, crc_on_q;
    logic [CNT_W-1:0]        total_q, idx_q;
    logic [7:0]              cur_byte;
    logic [6:0]              crc_val;
    logic                    sh_done, accept, last_byte, in_hdr;

    spi_frame_layout u_layout (
        .op(opcode), .addr(addr), .arg(arg), .clockless(clockless), .crc_en(crc_en),
        .hdr(l_hdr), .hdr_len(l_hdr_len), .pad_len(l_pad_len), .op_ok(l_ok)
    );

    assign accept    = start && (state == ST_IDLE);
    assign last_byte = (idx_q == total_q - 1'b1);
    assign in_hdr    = (idx_q < CNT_W'(hdr_len_q));

    always_comb begin
        if (in_hdr)
            cur_byte = hdr_q[idx_q[2:0]];
        else if (crc_on_q && idx_q == CNT_W'(hdr_len_q))
            cur_byte = {crc_val, 1'b0};
        else
            cur_byte = 8'h00;
    end

    spi_crc7_accum u_crc (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .en(state == ST_SEND && in_hdr), .din(cur_byte), .crc(crc_val)
    );

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(state == ST_SEND), .tx_byte(cur_byte),
        .miso(miso), .sclk(sclk), .mosi(mosi), .byte_done(sh_done), .rx_byte(rx_byte)
    );

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept && l_ok) nxt = ST_SEND;
            ST_SEND: nxt = ST_WAIT;
            ST_WAIT: if (sh_done) nxt = last_byte ? ST_DONE : ST_SEND;
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Frame context and counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q      <= '0;
            hdr_len_q  <= '0;
            crc_on_q   <= 1'b0;
            total_q    <= '0;
            idx_q      <= '0;
            byte_count <= '0;
            bad_op     <= 1'b0;
        end else begin
            bad_op <= accept && !l_ok;
            if (accept && l_ok) begin
                hdr_q     <= l_hdr;
                hdr_len_q <= l_hdr_len;
                crc_on_q  <= crc_en;
                total_q   <= CNT_W'(l_hdr_len) + CNT_W'(crc_en) + CNT_W'(l_pad_len);
                idx_q     <= '0;
            end else if (state == ST_WAIT && sh_done) begin
                if (last_byte) byte_count <= total_q;
                else           idx_q      <= idx_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        cs_n     = !(state == ST_SEND || state == ST_WAIT);
        rx_valid = sh_done;
    end

endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             bad_op,
    input logic             cs_n,
    input logic             sclk,
    input logic             rx_valid,
    input logic [CNT_W-1:0] byte_count
);

    assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (!busy && cs_n));

    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_count >= CNT_W'(5) && byte_count <= CNT_W'(15)));

    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_cs_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !cs_n);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_rx_in_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

endmodule

bind spi_cmd_framer spi_cmd_framer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bad_op(bad_op),
    .cs_n(cs_n), .sclk(sclk), .rx_valid(rx_valid), .byte_count(byte_count)
);

// File: tb/sim_spi_cmd_framer.sv
module sim_spi_cmd_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [23:0] addr = '0;
    logic [31:0] arg = '0;
    logic        clockless = 1'b0;
    logic        crc_en = 1'b0;
    logic        miso;
    logic        busy, done, bad_op, cs_n, sclk, mosi, rx_valid;
    logic [4:0]  byte_count;
    logic [7:0]  rx_byte;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_cmd_framer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr), .arg(arg),
        .clockless(clockless), .crc_en(crc_en), .miso(miso), .busy(busy), .done(done),
        .bad_op(bad_op), .byte_count(byte_count), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    // Slave model: bit counter restarts when chip select falls.
    int         g = 0;
    logic [7:0] cur = '0;
    logic [7:0] cap_q[$];
    logic [7:0] rx_q[$];

    function automatic logic [7:0] pat(input int k);
        return 8'(8'h5A + k * 37);
    endfunction

    always @(posedge sclk or negedge cs_n) begin
        if (sclk) begin
            if (!cs_n) begin
                cur = {cur[6:0], mosi};
                if (g % 8 == 7) cap_q.push_back(cur);
                g = g + 1;
            end
        end else begin
            g = 0;
        end
    end

    always_comb begin
        logic [7:0] pb;
        pb = pat(g / 8);
        miso = pb[7 - (g % 8)];
    end

    always @(negedge clk) if (rst_n && rx_valid) rx_q.push_back(rx_byte);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the serial idle level against chip select.
    always @(negedge clk) begin
        if (rst_n && cs_n && sclk) begin
            n_chk++; n_fail++;
            $display("FAIL R9 sclk high outside window: actual 1 expected 0");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [6:0] crc_of(input logic [7:0] q[$]);
        logic [6:0] c = 7'h7F;
        foreach (q[j]) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[6] ^ q[j][b];
                c = {c[5:0], 1'b0};
                if (fb) c = c ^ 7'h09;
            end
        end
        return c;
    endfunction

    task automatic build_exp(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                             input logic cl, input logic ce, output logic [7:0] e[$]);
        int pad;
        e = {};
        e.push_back(op);
        pad = 5;
        case (op)
            8'hCA: begin e.push_back(a[23:16]); e.push_back(a[15:8]); e.push_back(a[7:0]); pad = ce ? 10 : 8; end
            8'hC9: begin e.push_back(a[23:16]); e.push_back(a[15:8]); e.push_back(a[7:0]);
                         e.push_back(d[31:24]); e.push_back(d[23:16]); e.push_back(d[15:8]); e.push_back(d[7:0]); end
            8'hC4: begin e.push_back({a[15] | cl, a[14:8]}); e.push_back(a[7:0]); e.push_back(8'h00); pad = ce ? 10 : 8; end
            8'hC3: begin e.push_back({a[15] | cl, a[14:8]}); e.push_back(a[7:0]);
                         e.push_back(d[31:24]); e.push_back(d[23:16]); e.push_back(d[15:8]); e.push_back(d[7:0]); end
            8'hC5, 8'hC6: begin repeat (3) e.push_back(8'h00); pad = 6; end
            8'hCF: begin repeat (3) e.push_back(8'hFF); pad = 6; end
            8'hC1, 8'hC2: begin e.push_back(a[23:16]); e.push_back(a[15:8]); e.push_back(a[7:0]);
                               e.push_back(d[15:8]); e.push_back(d[7:0]); end
            default: begin e.push_back(a[23:16]); e.push_back(a[15:8]); e.push_back(a[7:0]);
                           e.push_back(d[23:16]); e.push_back(d[15:8]); e.push_back(d[7:0]); end
        endcase
        if (ce) e.push_back({crc_of(e), 1'b0});
        repeat (pad) e.push_back(8'h00);
    endtask

    task automatic run_frame(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                             input logic cl, input logic ce, input string req, input bit disturb);
        logic [7:0] e[$];
        int w = 0;
        bit busy_ok = 1;
        bit bytes_ok = 1;
        bit rx_ok = 1;
        int bad_i = 0;
        build_exp(op, a, d, cl, ce, e);
        cap_q.delete();
        rx_q.delete();
        @(negedge clk);
        opcode = op; addr = a; arg = d; clockless = cl; crc_en = ce; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && cs_n === 1'b0, "R11", "busy after start", busy, 1);
        while (done !== 1'b1 && w < 5000) begin
            if (disturb && w == 40) begin start = 1'b1; opcode = 8'hCF; addr = '1; end
            if (disturb && w == 41) begin start = 1'b0; opcode = op; addr = a; end
            @(negedge clk);
            w++;
            if (busy !== 1'b1) busy_ok = 0;
        end
        chk(done === 1'b1, req, "done seen", done, 1);
        chk(busy_ok, "R11", "busy held through frame", busy_ok, 1);
        chk(byte_count == e.size(), "R8", "byte_count", byte_count, e.size());
        chk(cap_q.size() == e.size(), req, "bytes on MOSI", cap_q.size(), e.size());
        foreach (e[i]) if (i < cap_q.size() && bytes_ok && cap_q[i] !== e[i]) begin bytes_ok = 0; bad_i = i; end
        chk(bytes_ok, req, $sformatf("frame byte %0d", bad_i), bytes_ok ? 0 : cap_q[bad_i], bytes_ok ? 0 : e[bad_i]);
        chk(rx_q.size() == e.size(), "R12", "rx_valid count", rx_q.size(), e.size());
        foreach (rx_q[i]) if (rx_ok && rx_q[i] !== pat(i)) begin rx_ok = 0; bad_i = i; end
        chk(rx_ok, "R12", $sformatf("rx byte %0d", bad_i), rx_ok ? 0 : rx_q[bad_i], rx_ok ? 0 : pat(bad_i));
        @(negedge clk);
        chk(busy === 1'b0 && cs_n === 1'b1, "R11", "idle after done", busy, 0);
        if (disturb) begin
            bit quiet = 1;
            repeat (40) begin @(negedge clk); if (busy !== 1'b0 || cs_n !== 1'b1) quiet = 0; end
            chk(quiet, "R10", "no second frame", quiet, 1);
        end
    endtask

    task automatic bad_frame(input logic [7:0] op);
        bit quiet = 1;
        @(negedge clk);
        opcode = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(bad_op === 1'b1 && busy === 1'b0 && cs_n === 1'b1, "R1", $sformatf("reject 0x%0h", op), bad_op, 1);
        @(negedge clk);
        chk(bad_op === 1'b0, "R1", "bad_op single pulse", bad_op, 0);
        repeat (30) begin @(negedge clk); if (cs_n !== 1'b1 || sclk !== 1'b0 || done !== 1'b0) quiet = 0; end
        chk(quiet, "R1", "nothing sent", quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && bad_op === 1'b0, "R11", "reset status", busy, 0);
        chk(cs_n === 1'b1 && sclk === 1'b0 && rx_valid === 1'b0, "R9", "reset serial idle", cs_n, 1);
        chk(byte_count == 5'd0, "R8", "reset byte_count", byte_count, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(8'hCA, 24'h12_3456, 32'h0, 1'b0, 1'b1, "R2", 0);
        run_frame(8'hCA, 24'hAB_CDEF, 32'h0, 1'b0, 1'b0, "R7", 0);
        run_frame(8'hC9, 24'h00_1000, 32'hDEAD_BEEF, 1'b0, 1'b1, "R2", 0);
        run_frame(8'hC4, 24'h00_0024, 32'h0, 1'b1, 1'b1, "R3", 0);
        run_frame(8'hC4, 24'h00_E840, 32'h0, 1'b0, 1'b0, "R3", 0);
        run_frame(8'hC3, 24'h00_0010, 32'h0102_0304, 1'b1, 1'b1, "R3", 0);
        run_frame(8'hC3, 24'h00_3A55, 32'hF00D_CAFE, 1'b0, 1'b0, "R7", 0);
        run_frame(8'hC5, 24'hFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R4", 0);
        run_frame(8'hC6, 24'h00_0000, 32'h0, 1'b0, 1'b0, "R4", 0);
        run_frame(8'hCF, 24'h00_0000, 32'h0, 1'b0, 1'b1, "R4", 0);
        run_frame(8'hC1, 24'h01_0203, 32'hAA55_1234, 1'b0, 1'b1, "R5", 0);
        run_frame(8'hC2, 24'h7F_FF00, 32'h0000_0800, 1'b0, 1'b0, "R5", 0);
        run_frame(8'hC7, 24'h03_0405, 32'h00AB_CDEF, 1'b0, 1'b1, "R5", 0);
        run_frame(8'hC8, 24'hC0_FFEE, 32'h9912_3456, 1'b0, 1'b1, "R6", 0);
        run_frame(8'hC9, 24'h5A_5A5A, 32'h8000_0001, 1'b0, 1'b1, "R10", 1);
        bad_frame(8'hCB);
        bad_frame(8'hC0);
        bad_frame(8'hCE);
        run_frame(8'hC2, 24'h11_2233, 32'h0000_4455, 1'b0, 1'b1, "R9", 0);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule